// File: doc/BRIEF.md
# Serial-fed flash word programmer

This block sits between a byte-wide serial receiver and the data port of an on-chip flash. It gathers incoming bytes into 32-bit words, with the first byte of each group in the least significant lane. Each complete word goes out as a single-beat write on a memory-mapped write master. The block holds the strobe for as long as the slave stalls, and a stall of a millisecond or more is handled the same way as a short one.

After every accepted write, the block reads a status register on a second memory-mapped master. It keeps reading while the busy field reports activity. Once the field reports idle, the block samples the success bit. The next word is taken only after a good result. A rejected write, or a byte that arrives when no room is left for it, stops the block in a sticky error state. A programmable word count marks the end of the image, and done rises once the last word has been confirmed.

While a word is being written or verified, the serial side may keep sending. One early byte is parked in a single-entry slot and joins the next word in order. A second early byte is an overrun.

Top module: `flash_word_loader`

## Requirements
- R1: Every four accepted bytes form one 32-bit write word. The first byte lands in bits 7:0, the second in 15:8, the third in 23:16 and the fourth in 31:24.
- R2: The write strobe stays high, with address and data unchanged, for every cycle in which waitrequest is high. It drops in the cycle after the one in which waitrequest is seen low. The burst count output always reads 1.
- R3: After reset the write address equals BASE_ADDR. It grows by exactly one after each accepted write.
- R4: After each accepted write, the status register is read. The read repeats while the busy field (status bits 1:0) is non-zero. No write and no status read are ever active in the same cycle. The next word is written only after an idle status shows success (status bit 2 set).
- R5: An idle status with bit 2 clear sets error with err_code 2'b01. The error state lasts until reset, and bytes received afterwards cause no write.
- R6: A byte that arrives while a word is waiting, being written or being verified is held in one slot. It becomes the next byte of the following word without loss or reordering. This holds even when it drains in the same cycle that a new byte arrives.
- R7: A byte that arrives while the holding slot is already occupied and the block is still busy sets error with err_code 2'b10.
- R8: Done rises after word_count words have been confirmed and stays high until reset. Done and error are never both high, and bytes after done cause no write.
- R9: After reset, done, error, the write strobe and the status read are all low, and err_code is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte strobe from the serial receiver |
| rx_byte | input | 8 | Received byte |
| word_count | input | CNT_W | Number of words in the image |
| dat_address | output | ADDR_W | Flash data word address |
| dat_write | output | 1 | Flash data write strobe |
| dat_writedata | output | 32 | Flash data write word |
| dat_burstcount | output | BURST_W | Burst length, fixed at 1 |
| dat_waitrequest | input | 1 | Flash data port stall |
| csr_address | output | CSR_AW | Status register address |
| csr_read | output | 1 | Status read strobe |
| csr_readdata | input | 32 | Status read data |
| csr_waitrequest | input | 1 | Status port stall |
| done | output | 1 | Image fully written and confirmed |
| error | output | 1 | Sticky failure flag |
| err_code | output | 2 | 01 write rejected, 10 byte overrun |

## Verification
The two functions that can meet in one cycle are the draining of the held byte into the packer and the arrival of a fresh byte, which must take the slot that was just freed. The bench provokes this by parking one byte during a long write stall. It then watches the status read strobe fall, which is the point where the block has just gone idle. On the very next edge it drives the next byte, followed by two more back to back. The collision is judged correct when the second word written equals the parked byte followed by the three new bytes in little-endian order, with no error raised.

// File: rtl/flw_pkg.sv
package flw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WRITE,
      ST_POLL,
      ST_DONE,
      ST_FAIL
   } flw_state_t;

   localparam logic [1:0] FAIL_NONE    = 2'b00;
   localparam logic [1:0] FAIL_REJECT  = 2'b01;
   localparam logic [1:0] FAIL_OVERRUN = 2'b10;

endpackage

// File: rtl/flw_byte_packer.sv
module flw_byte_packer #(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned LANES     = 4,
   parameter bit          MSB_FIRST = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      halt,
   input  logic                      busy_in,
   input  logic                      take,
   input  logic                      rx_valid,
   input  logic [BYTE_W-1:0]         rx_byte,
   output logic [LANES*BYTE_W-1:0]   word_out,
   output logic                      word_full,
   output logic                      overrun
);

   localparam int unsigned LANE_IW = (LANES > 1) ? $clog2(LANES) : 1;

   logic [LANE_IW-1:0] lane_cnt;
   logic [BYTE_W-1:0]  lane_q [LANES];
   logic               hold_vld;
   logic [BYTE_W-1:0]  hold_byte;
   logic               full_q;

   logic               blocked;
   logic               load_hold;
   logic               load_direct;
   logic               load_en;
   logic [BYTE_W-1:0]  load_byte;
   logic               last_lane;

   assign blocked     = full_q | busy_in;
   assign load_hold   = !halt && !blocked && hold_vld;
   assign load_direct = !halt && !blocked && !hold_vld && rx_valid;
   assign load_en     = load_hold | load_direct;
   assign load_byte   = hold_vld ? hold_byte : rx_byte;
   assign last_lane   = (lane_cnt == LANE_IW'(LANES - 1));
   assign overrun     = !halt && blocked && hold_vld && rx_valid;
   assign word_full   = full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane_cnt <= '0;
         full_q   <= 1'b0;
      end else begin
         if (take) begin
            full_q <= 1'b0;
         end else if (load_en && last_lane) begin
            full_q <= 1'b1;
         end
         if (load_en) begin
            lane_cnt <= last_lane ? '0 : lane_cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_vld  <= 1'b0;
         hold_byte <= '0;
      end else if (!halt) begin
         if (load_hold) begin
            hold_vld  <= rx_valid;
            hold_byte <= rx_byte;
         end else if (blocked && rx_valid && !hold_vld) begin
            hold_vld  <= 1'b1;
            hold_byte <= rx_byte;
         end
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q[i] <= '0;
         end else if (load_en && lane_cnt == LANE_IW'(i)) begin
            lane_q[i] <= load_byte;
         end
      end
      if (MSB_FIRST) begin : g_msb
         assign word_out[(LANES-1-i)*BYTE_W +: BYTE_W] = lane_q[i];
      end else begin : g_lsb
         assign word_out[i*BYTE_W +: BYTE_W] = lane_q[i];
      end
   end

endmodule

// File: rtl/flw_wr_master.sv
module flw_wr_master #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned BURST_W   = 4,
   parameter int unsigned BASE_ADDR = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [DATA_W-1:0]  start_data,
   output logic [ADDR_W-1:0]  wr_address,
   output logic               wr_write,
   output logic [DATA_W-1:0]  wr_writedata,
   output logic [BURST_W-1:0] wr_burstcount,
   input  logic               wr_waitrequest,
   output logic               accepted
);

   logic              req_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   assign accepted      = req_q && !wr_waitrequest;
   assign wr_write      = req_q;
   assign wr_address    = addr_q;
   assign wr_writedata  = data_q;
   assign wr_burstcount = BURST_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         addr_q <= ADDR_W'(BASE_ADDR);
         data_q <= '0;
      end else if (start) begin
         req_q  <= 1'b1;
         data_q <= start_data;
      end else if (accepted) begin
         req_q  <= 1'b0;
         addr_q <= addr_q + 1'b1;
      end
   end

endmodule

// File: rtl/flw_status_poll.sv
module flw_status_poll #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned CSR_AW      = 3,
   parameter int unsigned STATUS_ADDR = 0,
   parameter int unsigned BUSY_LSB    = 0,
   parameter int unsigned BUSY_W      = 2,
   parameter int unsigned OK_BIT      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic [CSR_AW-1:0] csr_address,
   output logic              csr_read,
   input  logic [DATA_W-1:0] csr_readdata,
   input  logic              csr_waitrequest,
   output logic              fin,
   output logic              ok
);

   logic req_q;
   logic rsp;
   logic busy_now;
   logic unused_rdata;

   assign csr_address  = CSR_AW'(STATUS_ADDR);
   assign csr_read     = req_q;
   assign rsp          = req_q && !csr_waitrequest;
   assign busy_now     = |csr_readdata[BUSY_LSB +: BUSY_W];
   assign fin          = rsp && !busy_now;
   assign ok           = csr_readdata[OK_BIT];
   assign unused_rdata = &{1'b0, csr_readdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else if (start) begin
         req_q <= 1'b1;
      end else if (fin) begin
         req_q <= 1'b0;
      end
   end

endmodule

// File: rtl/flash_word_loader.sv
module flash_word_loader #(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned LANES       = 4,
   parameter bit          MSB_FIRST   = 1'b0,
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned BASE_ADDR   = 'h100,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned BURST_W     = 4,
   parameter int unsigned CSR_AW      = 3,
   parameter int unsigned STATUS_ADDR = 0,
   parameter int unsigned BUSY_LSB    = 0,
   parameter int unsigned BUSY_W      = 2,
   parameter int unsigned OK_BIT      = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rx_valid,
   input  logic [BYTE_W-1:0]        rx_byte,
   input  logic [CNT_W-1:0]         word_count,
   output logic [ADDR_W-1:0]        dat_address,
   output logic                     dat_write,
   output logic [BYTE_W*LANES-1:0]  dat_writedata,
   output logic [BURST_W-1:0]       dat_burstcount,
   input  logic                     dat_waitrequest,
   output logic [CSR_AW-1:0]        csr_address,
   output logic                     csr_read,
   input  logic [BYTE_W*LANES-1:0]  csr_readdata,
   input  logic                     csr_waitrequest,
   output logic                     done,
   output logic                     error,
   output logic [1:0]               err_code
);

   import flw_pkg::*;

   localparam int unsigned DATA_W = BYTE_W * LANES;

   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (OK_BIT >= DATA_W) begin : g_bad_ok
      $error("OK_BIT outside status word");
   end
   if (BUSY_W < 1 || BUSY_LSB + BUSY_W > DATA_W) begin : g_bad_busy
      $error("busy field outside status word");
   end
   if (OK_BIT >= BUSY_LSB && OK_BIT < BUSY_LSB + BUSY_W) begin : g_bad_overlap
      $error("OK_BIT overlaps busy field");
   end
   if (BURST_W < 1 || ADDR_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("widths must be non-zero");
   end

   flw_state_t        state_q, state_d;
   logic [CNT_W-1:0]  verified_q;
   logic [1:0]        fail_q, fail_d;
   logic              cnt_inc;

   logic [DATA_W-1:0] packed_word;
   logic              word_full;
   logic              overrun;
   logic              take;
   logic              wr_accepted;
   logic              poll_start;
   logic              poll_fin;
   logic              poll_ok;
   logic              halt;
   logic              busy;

   assign halt = (state_q == ST_DONE) || (state_q == ST_FAIL);
   assign busy = (state_q != ST_IDLE);

   flw_byte_packer #(
      .BYTE_W    (BYTE_W),
      .LANES     (LANES),
      .MSB_FIRST (MSB_FIRST)
   ) u_packer (
      .clk       (clk),
      .rst_n     (rst_n),
      .halt      (halt),
      .busy_in   (busy),
      .take      (take),
      .rx_valid  (rx_valid),
      .rx_byte   (rx_byte),
      .word_out  (packed_word),
      .word_full (word_full),
      .overrun   (overrun)
   );

   flw_wr_master #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .BURST_W   (BURST_W),
      .BASE_ADDR (BASE_ADDR)
   ) u_wr (
      .clk            (clk),
      .rst_n          (rst_n),
      .start          (take),
      .start_data     (packed_word),
      .wr_address     (dat_address),
      .wr_write       (dat_write),
      .wr_writedata   (dat_writedata),
      .wr_burstcount  (dat_burstcount),
      .wr_waitrequest (dat_waitrequest),
      .accepted       (wr_accepted)
   );

   flw_status_poll #(
      .DATA_W      (DATA_W),
      .CSR_AW      (CSR_AW),
      .STATUS_ADDR (STATUS_ADDR),
      .BUSY_LSB    (BUSY_LSB),
      .BUSY_W      (BUSY_W),
      .OK_BIT      (OK_BIT)
   ) u_poll (
      .clk             (clk),
      .rst_n           (rst_n),
      .start           (poll_start),
      .csr_address     (csr_address),
      .csr_read        (csr_read),
      .csr_readdata    (csr_readdata),
      .csr_waitrequest (csr_waitrequest),
      .fin             (poll_fin),
      .ok              (poll_ok)
   );

   always_comb begin
      state_d    = state_q;
      fail_d     = fail_q;
      take       = 1'b0;
      poll_start = 1'b0;
      cnt_inc    = 1'b0;
      if (overrun && !halt) begin
         state_d = ST_FAIL;
         fail_d  = FAIL_OVERRUN;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (verified_q == word_count) begin
                  state_d = ST_DONE;
               end else if (word_full) begin
                  take    = 1'b1;
                  state_d = ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (wr_accepted) begin
                  poll_start = 1'b1;
                  state_d    = ST_POLL;
               end
            end
            ST_POLL: begin
               if (poll_fin) begin
                  if (poll_ok) begin
                     cnt_inc = 1'b1;
                     state_d = ST_IDLE;
                  end else begin
                     state_d = ST_FAIL;
                     fail_d  = FAIL_REJECT;
                  end
               end
            end
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         fail_q     <= FAIL_NONE;
         verified_q <= '0;
      end else begin
         state_q <= state_d;
         fail_q  <= fail_d;
         if (cnt_inc) begin
            verified_q <= verified_q + 1'b1;
         end
      end
   end

   assign done     = (state_q == ST_DONE);
   assign error    = (state_q == ST_FAIL);
   assign err_code = fail_q;

endmodule

// File: rtl/flw_checker.sv
module flw_checker #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] dat_address,
   input logic              dat_write,
   input logic [DATA_W-1:0] dat_writedata,
   input logic              dat_waitrequest,
   input logic              csr_read,
   input logic              done,
   input logic              error,
   input logic [1:0]        err_code
);

   assert_write_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dat_write && dat_waitrequest |=> dat_write && $stable(dat_address) && $stable(dat_writedata));

   assert_write_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dat_write && !dat_waitrequest |=> !dat_write);

   assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dat_write && !dat_waitrequest |=> dat_address == ADDR_W'($past(dat_address) + 1));

   assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(dat_write && csr_read));

   assert_error_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> error);

   assert_no_write_after_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
      error && !dat_write |=> !dat_write);

   assert_code_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_code != 2'b00) == error);

   assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   assert_done_error_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error));

endmodule

bind flash_word_loader flw_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .dat_address     (dat_address),
   .dat_write       (dat_write),
   .dat_writedata   (dat_writedata),
   .dat_waitrequest (dat_waitrequest),
   .csr_read        (csr_read),
   .done            (done),
   .error           (error),
   .err_code        (err_code)
);

// File: tb/flash_word_loader_tb.sv
module flash_word_loader_tb;

   localparam int unsigned BASE = 'h100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic [15:0] word_count = 16'd4;
   logic [15:0] dat_address;
   logic        dat_write;
   logic [31:0] dat_writedata;
   logic [3:0]  dat_burstcount;
   logic        dat_waitrequest = 1'b1;
   logic [2:0]  csr_address;
   logic        csr_read;
   logic [31:0] csr_readdata = 32'h0;
   logic        csr_waitrequest = 1'b0;
   logic        done;
   logic        error;
   logic [1:0]  err_code;

   always #4 clk = ~clk;

   flash_word_loader u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .rx_valid        (rx_valid),
      .rx_byte         (rx_byte),
      .word_count      (word_count),
      .dat_address     (dat_address),
      .dat_write       (dat_write),
      .dat_writedata   (dat_writedata),
      .dat_burstcount  (dat_burstcount),
      .dat_waitrequest (dat_waitrequest),
      .csr_address     (csr_address),
      .csr_read        (csr_read),
      .csr_readdata    (csr_readdata),
      .csr_waitrequest (csr_waitrequest),
      .done            (done),
      .error           (error),
      .err_code        (err_code)
   );

   // entry = {word, write stall cycles, busy status reads}
   localparam logic [47:0] VEC [0:3] = '{
      {32'h0403_0201, 8'd0, 8'd0},
      {32'hDEAD_BEEF, 8'd3, 8'd2},
      {32'h8000_0001, 8'd1, 8'd0},
      {32'h0F1E_2D3C, 8'd5, 8'd1}
   };

   int          n_chk = 0;
   int          n_fail = 0;
   int          n_wr = 0;
   int          n_rd = 0;
   int          wr_hi = 0;
   int          stall_left = 0;
   int          busy_left = 0;
   logic        ok_cfg = 1'b1;
   logic [31:0] log_data [0:15];
   logic [15:0] log_addr [0:15];

   // flash data port and status port models
   always @(negedge clk) begin
      if (dat_write) begin
         wr_hi = wr_hi + 1;
         if (stall_left > 0) begin
            dat_waitrequest = 1'b1;
            stall_left = stall_left - 1;
         end else begin
            dat_waitrequest = 1'b0;
            if (n_wr < 16) begin
               log_data[n_wr] = dat_writedata;
               log_addr[n_wr] = dat_address;
            end
            n_wr = n_wr + 1;
         end
      end else begin
         dat_waitrequest = 1'b1;
      end
      if (csr_read) begin
         n_rd = n_rd + 1;
         if (busy_left > 0) begin
            csr_readdata = 32'h0000_0001;
            busy_left = busy_left - 1;
         end else begin
            csr_readdata = ok_cfg ? 32'h0000_0004 : 32'h0000_0000;
         end
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk = n_chk + 1;
      if (act !== exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic do_reset(input logic [15:0] wc);
      @(negedge clk);
      rst_n = 1'b0;
      rx_valid = 1'b0;
      word_count = wc;
      n_wr = 0;
      n_rd = 0;
      wr_hi = 0;
      stall_left = 0;
      busy_left = 0;
      ok_cfg = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b);
      rx_valid = 1'b1;
      rx_byte = b;
      @(negedge clk);
      rx_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic send_word(input logic [31:0] w);
      for (int k = 0; k < 4; k++) begin
         send_byte(w[k*8 +: 8]);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual hung expected finish");
      report();
      $finish;
   end

   initial begin
      int prev_rd;
      int prev_wr;
      // ---------- reset state ----------
      do_reset(16'd4);
      chk("R9 done", done, 0);
      chk("R9 error", error, 0);
      chk("R9 write", dat_write, 0);
      chk("R9 read", csr_read, 0);
      chk("R9 err_code", err_code, 0);
      chk("R3 base address", dat_address, BASE);
      chk("R2 burstcount", dat_burstcount, 1);

      // ---------- vector table ----------
      for (int i = 0; i < 4; i++) begin
         stall_left = int'(VEC[i][15:8]);
         busy_left  = int'(VEC[i][7:0]);
         ok_cfg = 1'b1;
         wr_hi = 0;
         prev_rd = n_rd;
         send_word(VEC[i][47:16]);
         repeat (30) @(negedge clk);
         chk("R1 packed word", log_data[i], VEC[i][47:16]);
         chk("R3 word address", log_addr[i], BASE + i);
         chk("R3 next address", dat_address, BASE + i + 1);
         chk("R2 strobe cycles", wr_hi, int'(VEC[i][15:8]) + 1);
         chk("R4 status reads", n_rd - prev_rd, int'(VEC[i][7:0]) + 1);
         chk("R8 done timing", done, (i == 3) ? 1 : 0);
      end
      chk("R8 no error", error, 0);
      prev_wr = n_wr;
      send_word(32'h1111_2222);
      repeat (30) @(negedge clk);
      chk("R8 bytes after done ignored", n_wr, prev_wr);
      chk("R8 done sticky", done, 1);

      // ---------- rejected write ----------
      do_reset(16'd2);
      stall_left = 2;
      busy_left = 1;
      ok_cfg = 1'b0;
      send_word(32'hA5A5_0001);
      repeat (30) @(negedge clk);
      chk("R5 error set", error, 1);
      chk("R5 err_code", err_code, 2'b01);
      chk("R5 no done", done, 0);
      ok_cfg = 1'b1;
      send_word(32'h0102_0304);
      repeat (30) @(negedge clk);
      chk("R5 bytes after error ignored", n_wr, 1);
      chk("R5 error sticky", error, 1);

      // ---------- held byte, drain colliding with arrival ----------
      do_reset(16'd4);
      stall_left = 6;
      busy_left = 2;
      send_word(32'h4433_2211);
      rx_valid = 1'b1;
      rx_byte = 8'h55;
      @(negedge clk);
      rx_valid = 1'b0;
      while (!csr_read) @(negedge clk);
      while (csr_read) @(negedge clk);
      rx_valid = 1'b1;
      rx_byte = 8'h66;
      @(negedge clk);
      rx_byte = 8'h77;
      @(negedge clk);
      rx_byte = 8'h88;
      @(negedge clk);
      rx_valid = 1'b0;
      repeat (30) @(negedge clk);
      chk("R6 write count", n_wr, 2);
      chk("R6 first word", log_data[0], 32'h4433_2211);
      chk("R6 held byte ordered", log_data[1], 32'h8877_6655);
      chk("R6 single early byte no error", error, 0);

      // ---------- overrun ----------
      do_reset(16'd4);
      stall_left = 20;
      send_word(32'hCAFE_0000);
      rx_valid = 1'b1;
      rx_byte = 8'h01;
      @(negedge clk);
      rx_byte = 8'h02;
      @(negedge clk);
      rx_valid = 1'b0;
      repeat (40) @(negedge clk);
      chk("R7 error set", error, 1);
      chk("R7 err_code", err_code, 2'b10);
      chk("R7 in-flight write finished", n_wr, 1);

      report();
      $finish;
   end

endmodule